// File: doc/BRIEF.md
# MSI doorbell to interrupt-line frame

This block is a memory-mapped frame that turns message-signalled interrupts into wired interrupt lines. A device that wants to interrupt writes a global interrupt number to a doorbell register. The frame checks whether that number falls inside the group of lines it owns. If it does, the frame raises the matching output line for exactly one clock. Software finds out which numbers the frame owns by reading a read-only type register. That register packs the first owned global number, which is the base offset plus 32, together with the line count.

The frame sits on a single-cycle 32-bit register port that decodes a 4 KB window of byte offsets. Read data is registered and appears in the cycle after the request. The frame also holds a fixed identification word and a block of identification registers that read as zero. Any access of the wrong size, or to an offset the frame does not map, sets a sticky error flag. Only reset clears that flag.

The base offset and the line count are elaboration parameters. At most 128 lines are allowed, and base+32+count may not exceed 1020. An illegal pair stops elaboration. The defaults are base 0 and 64 lines.

Top module: `msi_frame`

## Requirements
- R1: While reset is held, and right after it, every interrupt line is low, the error flag is low and the read data is zero.
- R2: A word read (size code 2'b10) at offset 0x008 returns ((BASE+32) << 16) | COUNT on the read data in the cycle after the request.
- R3: A word read at offset 0xFCC returns 0x0510_0000. A word read at any offset from 0xFD0 to 0xFFC inclusive returns zero. None of these reads sets the error flag.
- R4: A write at offset 0x040 of size half (2'b01) or word (2'b10) whose data bits [9:0] equal BASE+32+i, with 0 <= i < COUNT, drives line i high for exactly one cycle, starting in the cycle after the write. Data bits [31:10] are ignored. Only such a write drives any line.
- R5: A doorbell write whose data bits [9:0] fall below BASE+32, or at or above BASE+32+COUNT, drives no line and does not set the error flag.
- R6: Doorbell writes to different lines on consecutive cycles each give their own one-cycle pulse, in consecutive cycles. At most one line is high in any cycle.
- R7: A read whose size is not word (byte 2'b00, half 2'b01, reserved 2'b11) returns zero and sets the error flag. A doorbell write of byte or reserved size drives no line and sets the error flag.
- R8: An access to any offset outside those in R2 to R4 behaves as follows. A read returns zero. A write has no effect on any line. Either one sets the error flag. This includes a read of 0x040 and a write to 0x008.
- R9: Once set, the error flag stays high through any later accesses until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the 4 KB window |
| req_size | input | 2 | Access size: 00 byte, 01 half, 10 word, 11 reserved |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_rdata | output | 32 | Registered read data, valid the cycle after a read |
| irq_o | output | COUNT | Interrupt lines, one-cycle pulses |
| err_o | output | 1 | Sticky access error flag |

## Verification
The doorbell is tested with three kinds of value: the first and last owned numbers, the numbers just outside the range on each side, and values with junk in the upper data bits. Together these show an off-by-one in the rebasing, a missing mask and a range check that is too wide. Writes to two different lines on consecutive cycles show whether each pulse stays one cycle wide and lands on the right line. Random accesses mix offsets, sizes and directions, with doorbell values clustered around the owned range. These are compared against a bench model of the read data, the lines and the error flag, which separates a size check from an offset check. Two resets show that the error flag is sticky and that reset clears it.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned GID_W  = 10;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  localparam logic [ADDR_W-1:0] OFS_TYPE  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_DOOR  = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_IDENT = 12'hFCC;
  localparam logic [ADDR_W-1:0] OFS_ZLO   = 12'hFD0;
  localparam logic [ADDR_W-1:0] OFS_ZHI   = 12'hFFC;

  localparam logic [DATA_W-1:0] IDENT_VAL = 32'h0000_0051 << 20;
endpackage

// File: rtl/msi_frame_decode.sv
module msi_frame_decode
  import msi_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              rd_type,
  output logic              rd_ident,
  output logic              wr_door,
  output logic              err_q
);
  logic rd_size_ok;
  logic wr_size_ok;
  logic bad;
  logic err_d;
  logic err_en;

  assign rd_size_ok = (size == SZ_WORD);
  assign wr_size_ok = (size == SZ_WORD) || (size == SZ_HALF);

  always_comb begin
    rd_type  = 1'b0;
    rd_ident = 1'b0;
    wr_door  = 1'b0;
    bad      = 1'b0;
    if (valid) begin
      if (write) begin
        if (addr == OFS_DOOR && wr_size_ok) wr_door = 1'b1;
        else                                bad     = 1'b1;
      end else if (!rd_size_ok) begin
        bad = 1'b1;
      end else if (addr == OFS_TYPE) begin
        rd_type = 1'b1;
      end else if (addr == OFS_IDENT) begin
        rd_ident = 1'b1;
      end else if (addr < OFS_ZLO || addr > OFS_ZHI) begin
        bad = 1'b1;
      end
    end
  end

  assign err_en = bad;
  assign err_d  = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R9
  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(valid)); // R8
  AST_DOOR_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && write && addr == OFS_DOOR && size == SZ_BYTE) |=> err_q); // R7
endmodule

// File: rtl/msi_frame_doorbell.sv
module msi_frame_doorbell
  import msi_frame_pkg::*;
#(
  parameter int unsigned BASE  = 0,
  parameter int unsigned COUNT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_door,
  input  logic [GID_W-1:0] gid,
  output logic [COUNT-1:0] irq_q
);
  localparam int unsigned LOW   = BASE + 32;
  localparam int unsigned IDXW  = (COUNT > 1) ? $clog2(COUNT) : 1;
  localparam logic [GID_W:0] LOW_V = (GID_W+1)'(LOW);
  localparam logic [GID_W:0] TOP_V = (GID_W+1)'(LOW + COUNT);

  logic [GID_W:0]  gid_ext;
  logic [GID_W:0]  rebased;
  logic            in_range;
  logic            fire;
  logic [IDXW-1:0] idx;
  logic [COUNT-1:0] irq_d;
  logic            irq_en;

  assign gid_ext  = {1'b0, gid};
  assign in_range = (gid_ext >= LOW_V) && (gid_ext < TOP_V);
  assign rebased  = gid_ext - LOW_V;
  assign idx      = rebased[IDXW-1:0];
  assign fire     = wr_door && in_range;
  assign irq_en   = fire || (|irq_q);

  for (genvar i = 0; i < COUNT; i++) begin : g_line
    assign irq_d[i] = fire && (idx == IDXW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      irq_q[i] <= 1'b0;
      else if (irq_en) irq_q[i] <= irq_d[i];
    end
  end

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_q)); // R6
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_q) |-> $past(wr_door)); // R4
  AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|irq_q) && !wr_door) |=> (irq_q == '0)); // R4
  AST_DROP_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_door && gid_ext < LOW_V) |=> (irq_q == '0)); // R5
  AST_DROP_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_door && gid_ext >= TOP_V) |=> (irq_q == '0)); // R5
endmodule

// File: rtl/msi_frame_rdmux.sv
module msi_frame_rdmux
  import msi_frame_pkg::*;
#(
  parameter int unsigned BASE  = 0,
  parameter int unsigned COUNT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              rd_type,
  input  logic              rd_ident,
  output logic [DATA_W-1:0] rdata_q
);
  localparam logic [DATA_W-1:0] TYPE_VAL =
    (DATA_W'(BASE + 32) << 16) | DATA_W'(COUNT);

  logic [DATA_W-1:0] rdata_d;
  logic              rdata_en;

  always_comb begin
    if (rd_type)       rdata_d = TYPE_VAL;
    else if (rd_ident) rdata_d = IDENT_VAL;
    else               rdata_d = '0;
  end

  assign rdata_en = rd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  AST_RD_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_type |=> (rdata_q == TYPE_VAL)); // R2
  AST_RD_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_type && !rd_ident) |=> (rdata_q == '0)); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rdata_q)); // R3
endmodule

// File: rtl/msi_frame.sv
module msi_frame
  import msi_frame_pkg::*;
#(
  parameter int unsigned BASE  = 0,
  parameter int unsigned COUNT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [COUNT-1:0]  irq_o,
  output logic              err_o
);
  if (COUNT < 1 || COUNT > 128 || BASE + 32 + COUNT > 1020) begin : g_bad_cfg
    $error("msi_frame: illegal BASE/COUNT pair");
  end

  logic rst_s0;
  logic rst_s1;
  logic rd_type;
  logic rd_ident;
  logic wr_door;
  logic unused_wdata_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end

  assign unused_wdata_hi = ^req_wdata[DATA_W-1:GID_W];

  msi_frame_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_s1),
    .valid    (req_valid),
    .write    (req_write),
    .addr     (req_addr),
    .size     (req_size),
    .rd_type  (rd_type),
    .rd_ident (rd_ident),
    .wr_door  (wr_door),
    .err_q    (err_o)
  );

  msi_frame_doorbell #(.BASE(BASE), .COUNT(COUNT)) u_door (
    .clk     (clk),
    .rst_n   (rst_s1),
    .wr_door (wr_door),
    .gid     (req_wdata[GID_W-1:0]),
    .irq_q   (irq_o)
  );

  msi_frame_rdmux #(.BASE(BASE), .COUNT(COUNT)) u_rd (
    .clk      (clk),
    .rst_n    (rst_s1),
    .rd_req   (req_valid && !req_write),
    .rd_type  (rd_type),
    .rd_ident (rd_ident),
    .rdata_q  (rsp_rdata)
  );

  AST_READ_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_s1)
    (req_valid && !req_write) |=> (irq_o == '0)); // R4
  AST_BADOFS_WRITE: assert property (@(posedge clk) disable iff (!rst_s1)
    (req_valid && req_write && req_addr != OFS_DOOR) |=> (irq_o == '0 && err_o)); // R8
endmodule

// File: tb/msi_frame_tb.sv
module msi_frame_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TB_BASE  = 3;
  localparam int TB_COUNT = 40;
  localparam int LOW      = TB_BASE + 32;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                req_valid;
  logic                req_write;
  logic [11:0]         req_addr;
  logic [1:0]          req_size;
  logic [31:0]         req_wdata;
  logic [31:0]         rsp_rdata;
  logic [TB_COUNT-1:0] irq_o;
  logic                err_o;

  int  n_chk = 0;
  int  n_err = 0;
  logic exp_err;
  logic [31:0] exp_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_frame #(.BASE(TB_BASE), .COUNT(TB_COUNT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .irq_o(irq_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int line_of(input logic [31:0] d);
    int g = int'(d[9:0]);
    if (g >= LOW && g < LOW + TB_COUNT) return g - LOW;
    return -1;
  endfunction

  function automatic logic is_bad(input logic w, input logic [11:0] a, input logic [1:0] s);
    if (w) return !(a == 12'h040 && (s == 2'b01 || s == 2'b10));
    if (s != 2'b10) return 1'b1;
    return !(a == 12'h008 || a == 12'hFCC || (a >= 12'hFD0 && a <= 12'hFFC));
  endfunction

  function automatic logic [31:0] rd_val(input logic [11:0] a, input logic [1:0] s);
    if (s != 2'b10) return 32'h0;
    if (a == 12'h008) return (32'(LOW) << 16) | 32'(TB_COUNT);
    if (a == 12'hFCC) return 32'h0510_0000;
    return 32'h0;
  endfunction

  function automatic logic [TB_COUNT-1:0] vec_of(input int i);
    logic [TB_COUNT-1:0] v = '0;
    if (i >= 0) v[i] = 1'b1;
    return v;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_size = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 irq", 64'(irq_o), 64'h0);
    chk("R1 err", 64'(err_o), 64'h0);
    chk("R1 rdata", 64'(rsp_rdata), 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 irq after release", 64'(irq_o), 64'h0);
    exp_err = 1'b0; exp_rd = 32'h0;
  endtask

  task automatic access(input string req, input logic w, input logic [11:0] a,
                        input logic [1:0] s, input logic [31:0] d);
    int ln;
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    ln = (w && !is_bad(w, a, s)) ? line_of(d) : -1;
    if (is_bad(w, a, s)) exp_err = 1'b1;
    if (!w) exp_rd = rd_val(a, s);
    chk({req, " irq"}, 64'(irq_o), 64'(vec_of(ln)));
    chk({req, " err"}, 64'(err_o), 64'(exp_err));
    if (!w) chk({req, " rdata"}, 64'(rsp_rdata), 64'(exp_rd));
    @(negedge clk);
    chk({req, " pulse width"}, 64'(irq_o), 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();

    access("R2 type", 1'b0, 12'h008, 2'b10, 32'h0);
    access("R3 ident", 1'b0, 12'hFCC, 2'b10, 32'h0);
    access("R3 zero lo", 1'b0, 12'hFD0, 2'b10, 32'h0);
    access("R3 zero mid", 1'b0, 12'hFE4, 2'b10, 32'h0);
    access("R3 zero hi", 1'b0, 12'hFFC, 2'b10, 32'h0);
    access("R4 first line", 1'b1, 12'h040, 2'b10, 32'(LOW));
    access("R4 last line half", 1'b1, 12'h040, 2'b01, 32'(LOW + TB_COUNT - 1));
    access("R4 upper bits ignored", 1'b1, 12'h040, 2'b10, 32'hFFFF_FC00 | 32'(LOW + 7));
    access("R5 below", 1'b1, 12'h040, 2'b10, 32'(LOW - 1));
    access("R5 above", 1'b1, 12'h040, 2'b10, 32'(LOW + TB_COUNT));
    access("R5 max id", 1'b1, 12'h040, 2'b10, 32'h3FF);

    // R6: two doorbells on consecutive cycles
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h040; req_size = 2'b10;
    req_wdata = 32'(LOW + 2);
    @(negedge clk);
    req_wdata = 32'(LOW + 9);
    chk("R6 first pulse", 64'(irq_o), 64'(vec_of(2)));
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 second pulse", 64'(irq_o), 64'(vec_of(9)));
    @(negedge clk);
    chk("R6 quiet", 64'(irq_o), 64'h0);

    access("R7 half read of type", 1'b0, 12'h008, 2'b01, 32'h0);
    access("R9 sticky after good read", 1'b0, 12'hFCC, 2'b10, 32'h0);
    access("R7 byte doorbell dropped", 1'b1, 12'h040, 2'b00, 32'(LOW + 3));

    do_reset(); // R9: reset clears the flag
    access("R8 read doorbell ofs", 1'b0, 12'h040, 2'b10, 32'h0);
    access("R8 write to unmapped", 1'b1, 12'h044, 2'b10, 32'(LOW + 1));
    access("R8 write to type", 1'b1, 12'h008, 2'b10, 32'(LOW + 1));
    access("R9 sticky after good doorbell", 1'b1, 12'h040, 2'b10, 32'(LOW + 4));

    do_reset();
    for (int k = 0; k < 600; k++) begin
      logic        w;
      logic [11:0] a;
      logic [1:0]  s;
      logic [31:0] d;
      int          pick;
      w = 1'(($urandom % 3) != 0);
      pick = int'($urandom % 8);
      case (pick)
        0:       a = 12'h008;
        1:       a = 12'hFCC;
        2:       a = 12'hFD0 + 12'($urandom % 48);
        3:       a = 12'($urandom);
        default: a = 12'h040;
      endcase
      s = (($urandom % 4) == 0) ? 2'($urandom) : ((($urandom % 2) == 0) ? 2'b10 : 2'b01);
      d = $urandom;
      if (($urandom % 4) != 0) d[9:0] = 10'(LOW - 4 + int'($urandom % (TB_COUNT + 8)));
      if (w) access("R4 random doorbell", w, a, s, d);
      else   access("R8 random read", w, a, s, d);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule